// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block is a watchdog that counts ticks of a slow, free-running time base and raises a system reset request when the count reaches its terminal value. The time base reaches the block as a single-cycle enable, `tick_en`, in the block's own clock domain. Software keeps the system alive by writing one exact key byte, 0x5A, to a dedicated clear register. A write of any other value, or a write to any other address, leaves the count untouched.

A two-bit configuration input picks the operating mode. Mode 2'b00 is off: the count is held at zero and no reset request is made. Mode 2'b01 counts while the system is awake and freezes the count while `sleep` is high. Modes 2'b10 and 2'b11 are always-on: the block counts whether or not the system is asleep. Software has no write path that can stop the watchdog. The length of the watchdog period is a parameter, and it defaults to a power of two.

The reset request is a pulse one clock wide, and the count returns to zero when it fires. Stretching that pulse into a full system reset, and any delay before the system runs again, belong to the logic around this block.

Top module: `keyed_wdt`

## Requirements
- R1: A cycle with `wr_en`=1, `wr_addr`=CLR_ADDR (default 4'h3) and `wr_data`=8'h5A zeroes the count, and it does so even if `tick_en` is high in that cycle. That tick is lost, and a write in the overflow cycle suppresses the pulse. The next pulse then follows PERIOD further counted ticks.
- R2: A write has no effect on the count in any of these cases: a data value other than 8'h5A, an address other than CLR_ADDR, or `wr_en` low.
- R3: When PERIOD ticks have been counted since the count was last zero, `rst_req` is high in the clock cycle that follows the edge of the last tick. It stays high for exactly that one cycle.
- R4: The count is zero after a pulse, so the next pulse comes PERIOD counted ticks later.
- R5: The count advances only in cycles where `tick_en` is high.
- R6: In mode 2'b00 the count is held at zero and `rst_req` stays low. After the block leaves that mode, a full PERIOD of ticks is needed before a pulse.
- R7: In mode 2'b01 the count freezes while `sleep` is high and resumes from the same value when `sleep` falls.
- R8: In modes 2'b10 and 2'b11 the count advances on every tick, whether `sleep` is high or low.
- R9: While `rst_n` is low at a clock edge, the count is cleared and `rst_req` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle enable from the slow time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| sleep | input | 1 | System is in a low-power state |
| mode | input | 2 | 00 off, 01 run only while awake, 10/11 always on |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The count is never visible directly at the ports; it shows only as the cycle in which `rst_req` pulses. A count that is off by one, missed a clear, took a stray clear, or moved during sleep therefore shows up as a pulse one or more tick periods early or late, or as a missing pulse. In every case this is visible within one watchdog period of the fault. The bench pins down the exact cycle of each expected pulse and checks `rst_req` in every cycle of each window. Sweeps over every non-key data value, every foreign address and several tick spacings expose stray effects as a moved pulse.

// File: rtl/wdt_pkg.sv
// Package: shared mode encoding and the clear key for the keyed watchdog.
// Assumes an 8-bit key; wider data buses zero-extend it.
package wdt_pkg;
    typedef enum logic [1:0] {
        WDT_OFF     = 2'b00,
        WDT_AWAKE   = 2'b01,
        WDT_ALWAYS  = 2'b10,
        WDT_ALWAYS2 = 2'b11
    } wdt_mode_e;

    localparam logic [7:0] WDT_KEY = 8'h5A;
endpackage

// File: rtl/wdt_key_match.sv
// Module: recognises a write of the clear key to the clear address.
// Assumes write fields are valid in the cycle wr_en is high; purely combinational.
module wdt_key_match #(
    parameter int              AW       = 4,
    parameter int              DW       = 8,
    parameter logic [AW-1:0]   CLR_ADDR = '0,
    parameter logic [7:0]      KEY      = 8'h5A
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          clr_hit
);
    localparam logic [DW-1:0] KEY_EXT = DW'(KEY);

    // Purpose: flag an exact key write to the clear register.
    always_comb begin
        clr_hit = wr_en && (wr_addr == CLR_ADDR) && (wr_data == KEY_EXT);
    end
endmodule

// File: rtl/wdt_gate.sv
// Module: turns mode, sleep and the slow tick into count controls.
// Assumes mode is a static or slowly changing strap; no software path alters it.
module wdt_gate
    import wdt_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sleep,
    input  logic       tick_en,
    output logic       hold_zero,
    output logic       advance
);
    // Purpose: decode the operating mode into hold and advance strobes.
    always_comb begin
        hold_zero = 1'b0;
        advance   = 1'b0;
        unique case (wdt_mode_e'(mode))
            WDT_OFF:    hold_zero = 1'b1;
            WDT_AWAKE:  advance   = tick_en && !sleep;
            default:    advance   = tick_en;
        endcase
    end
endmodule

// File: rtl/wdt_count.sv
// Module: watchdog period counter with a registered one-cycle overflow pulse.
// Assumes PERIOD >= 2. Priority: reset, hold, key clear, advance.
module wdt_count #(
    parameter int PERIOD = 256,
    localparam int CW    = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_zero,
    input  logic          clr_hit,
    input  logic          advance,
    output logic [CW-1:0] count,
    output logic          fire
);
    localparam bit POW2 = (PERIOD == (1 << CW));

    logic at_term;

    // Purpose: pick the cheapest terminal detect for this period.
    generate
        if (POW2) begin : g_pow2
            always_comb at_term = &count;
        end else begin : g_cmp
            always_comb at_term = (count == CW'(PERIOD - 1));
        end
    endgenerate

    // Purpose: advance, clear or wrap the count and register the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            fire  <= 1'b0;
        end else if (hold_zero || clr_hit) begin
            count <= '0;
            fire  <= 1'b0;
        end else if (advance && at_term) begin
            count <= '0;
            fire  <= 1'b1;
        end else begin
            if (advance) count <= count + 1'b1;
            fire <= 1'b0;
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
// Module: keyed watchdog top. Counts slow ticks and requests a system reset
// on overflow unless the key byte is written to the clear register first.
// Assumes tick_en is already synchronous to clk and one cycle wide.
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int            PERIOD   = 256,
    parameter int            AW       = 4,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] CLR_ADDR = AW'(3),
    localparam int           CW       = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          sleep,
    input  logic [1:0]    mode,
    output logic          rst_req
);
    logic          clr_hit;
    logic          hold_zero;
    logic          advance;
    logic [CW-1:0] cnt_q;

    wdt_key_match #(
        .AW(AW), .DW(DW), .CLR_ADDR(CLR_ADDR), .KEY(WDT_KEY)
    ) u_key (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .clr_hit(clr_hit)
    );

    wdt_gate u_gate (
        .mode(mode), .sleep(sleep), .tick_en(tick_en),
        .hold_zero(hold_zero), .advance(advance)
    );

    wdt_count #(.PERIOD(PERIOD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold_zero(hold_zero), .clr_hit(clr_hit),
        .advance(advance), .count(cnt_q), .fire(rst_req)
    );
endmodule

// File: rtl/keyed_wdt_chk.sv
// Module: property checker for keyed_wdt, attached by bind below.
// Assumes the count is observed through the top's cnt_q net.
module keyed_wdt_chk #(
    parameter int            AW       = 4,
    parameter int            DW       = 8,
    parameter int            CW       = 8,
    parameter logic [AW-1:0] CLR_ADDR = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          sleep,
    input logic [1:0]    mode,
    input logic          rst_req,
    input logic [CW-1:0] cnt
);
    logic key_w;
    assign key_w = wr_en && (wr_addr == CLR_ADDR) && (wr_data == DW'(8'h5A));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !rst_req));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> cnt == '0);

    // R1
    key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_w |=> (cnt == '0 && !rst_req));

    // R6
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (cnt == '0 && !rst_req));

    // R7
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && sleep && !key_w) |=> (cnt == $past(cnt) && !rst_req));

    // R5
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && mode != 2'b00 && !key_w) |=> (cnt == $past(cnt) && !rst_req));

    // R8
    always_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && tick_en && !key_w) |=> (cnt != $past(cnt)));
endmodule

bind keyed_wdt keyed_wdt_chk #(
    .AW(AW), .DW(DW), .CW(CW), .CLR_ADDR(CLR_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sleep(sleep), .mode(mode),
    .rst_req(rst_req), .cnt(cnt_q)
);

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;
    localparam int P  = 16;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam logic [AW-1:0] CA = 4'h3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          sleep = 1'b0;
    logic [1:0]    mode = 2'b01;
    logic          rst_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    keyed_wdt #(.PERIOD(P), .AW(AW), .DW(DW), .CLR_ADDR(CA)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sleep(sleep), .mode(mode),
        .rst_req(rst_req)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag, input int step);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s step %0d: rst_req actual %0b expected %0b", tag, step, act, exp);
        end
    endtask

    // Runs n steps; tick in step i when i % div == 0; optional write in step ws.
    task automatic run(input int n, input int div, input int pulse_at, input int ws,
                       input logic en, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string tag);
        for (int i = 1; i <= n; i++) begin
            tick_en = ((i % div) == 0);
            wr_en   = (i == ws) ? en : 1'b0;
            wr_addr = a;
            wr_data = d;
            @(posedge clk);
            @(negedge clk);
            chk(rst_req, (i == pulse_at), tag, i);
        end
        wr_en   = 1'b0;
        tick_en = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(rst_req, 1'b0, "R9 reset", 0);
        rst_n = 1'b1;

        // R3 / R4: pulse after exactly P ticks, then again P later
        run(P, 1, P, 0, 0, '0, '0, "R3 first overflow");
        run(P, 1, P, 0, 0, '0, '0, "R4 wrap to zero");

        // R5: sparse ticks shift the pulse arithmetically
        for (int d = 2; d <= 4; d++) run(P * d, d, P * d, 0, 0, '0, '0, "R5 tick spacing");

        // R2: every non-key value at the clear address
        for (int v = 0; v < 256; v++)
            if (v != 8'h5A) run(P, 1, P, 5, 1'b1, CA, DW'(v), "R2 wrong value");
        // R2: key at every other address, and key with wr_en low
        for (int a = 0; a < (1 << AW); a++)
            if (a != CA) run(P, 1, P, 5, 1'b1, AW'(a), 8'h5A, "R2 wrong address");
        run(P, 1, P, 5, 1'b0, CA, 8'h5A, "R2 strobe low");

        // R1: key clear mid-count, at step 1, and in the overflow cycle
        run(10 + P, 1, 10 + P, 10, 1'b1, CA, 8'h5A, "R1 key mid count");
        run(1 + P, 1, 1 + P, 1, 1'b1, CA, 8'h5A, "R1 key first step");
        run(2 * P, 1, 2 * P, P, 1'b1, CA, 8'h5A, "R1 key at overflow");

        // R6: off mode holds zero, full period needed after re-enable
        run(7, 1, 0, 0, 0, '0, '0, "R6 pre count");
        mode = 2'b00;
        run(40, 1, 0, 0, 0, '0, '0, "R6 off mode");
        mode = 2'b01;
        run(P, 1, P, 0, 0, '0, '0, "R6 re-enable");

        // R7: awake-only mode freezes during sleep
        run(6, 1, 0, 0, 0, '0, '0, "R7 before sleep");
        sleep = 1'b1;
        run(30, 1, 0, 0, 0, '0, '0, "R7 sleeping");
        sleep = 1'b0;
        run(P - 6, 1, P - 6, 0, 0, '0, '0, "R7 resumed");

        // R8: always-on modes count through sleep
        sleep = 1'b1;
        mode = 2'b10;
        run(P, 1, P, 0, 0, '0, '0, "R8 always on 10");
        mode = 2'b11;
        run(P, 1, P, 0, 0, '0, '0, "R8 always on 11");
        sleep = 1'b0;
        mode = 2'b01;

        // R9: reset mid-count restarts the period
        run(9, 1, 0, 0, 0, '0, '0, "R9 pre reset");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rst_req, 1'b0, "R9 in reset", 0);
        rst_n = 1'b1;
        run(P, 1, P, 0, 0, '0, '0, "R9 after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule